// File: doc/BRIEF.md
# Strided Vector Register Loader

This block moves up to sixty-four 64-bit elements between a word-addressed, low-order interleaved main memory and one of eight on-block vector registers. A single start pulse captures a base word address, a signed constant stride, an element count, a register number and a direction (load or store). The block then walks the addresses base, base+stride, base+2*stride, and so on, presenting at most one element request per cycle to the memory. Each request goes to the bank named by the low four address bits.

Every bank stays occupied for four cycles after it is accessed. When the next element falls in a bank that is still occupied, the request waits until that bank frees up. Elements always leave in index order, so strides that revisit a bank quickly (0, 8, 16) run slower than unit stride. On a load, returned words fill consecutive element slots of the chosen register, and the memory's check bits are discarded. On a store, element slots are read out in order and sent with a write strobe. A combinational read port exposes any element of any register.

The controller is a four-state machine. IDLE waits for a start pulse. ISSUE sends element requests. DRAIN waits for outstanding load responses. FINISH raises the completion pulse for one cycle. Its transitions are: IDLE to ISSUE on start; ISSUE to ISSUE while elements remain; ISSUE to DRAIN on the final request of a load; ISSUE to FINISH on the final request of a store; DRAIN to FINISH when the final load word is written; FINISH to IDLE unconditionally.

Top module: `svl_loader`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done` and `mem_req` are all low.
- R2: A `start` pulse is accepted only in IDLE, where it captures base, stride, length, register number and direction. A `start` pulse while `busy` is high has no effect on the running transfer.
- R3: Element k is requested at word address base + k*stride, modulo 2^24, where stride is a 24-bit two's complement value. A stride of 0 repeats the same address and a negative stride walks downwards.
- R4: The bank of a request is `mem_addr[3:0]`. After a bank is requested in cycle t, it is not requested again before cycle t+4. Requests go out in element order, at most one per cycle, and each request is sent in the first cycle in which its bank is free.
- R5: `vec_len` sets the element count. Values 1 to 64 are used as given, 0 acts as 1 and values above 64 act as 64. Element slots at or above the count keep their previous contents.
- R6: On a load (`store_dir`=0), a read response arrives with `mem_rvalid` one cycle after its request. Bits [63:0] of `mem_rdata` are written into element slot k of the selected register, and bits [71:64] (check bits) are dropped.
- R7: On a store (`store_dir`=1), every request has `mem_we` high and carries element k of the selected register on `mem_wdata`.
- R8: `done` is a one-cycle pulse. For a load it comes two cycles after the final request, and for a store one cycle after it. `busy` is high from the cycle after an accepted start up to and including the `done` cycle, and `mem_req` is only high while `busy` is high.
- R9: `vr_rd_data` shows, combinationally, element `vr_rd_idx` of register `vr_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted in IDLE only) |
| store_dir | input | 1 | 0 = memory to register, 1 = register to memory |
| vr_sel | input | 3 | Vector register used by the transfer |
| base_addr | input | 24 | Word address of element 0 |
| stride | input | 24 | Signed address step between elements |
| vec_len | input | 7 | Element count (clamped to 1..64) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Element request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Word address of the request |
| mem_wdata | output | 64 | Store data |
| mem_rvalid | input | 1 | Read response valid (one cycle after request) |
| mem_rdata | input | 72 | Read response: check bits [71:64], data [63:0] |
| vr_rd_sel | input | 3 | Register number for the read port |
| vr_rd_idx | input | 6 | Element slot for the read port |
| vr_rd_data | output | 64 | Element value at the read port |

## Verification
During a load, the write of a returned word into the register file and the stall of the next request on an occupied bank can fall in the same cycle, because the response to element k arrives while element k+1 waits. Loads with strides 0, 8 and 16 and short random lengths force this overlap many times. The bench judges it two ways: each request's cycle is compared with a bank-occupancy schedule computed in the bench, and afterwards all sixty-four slots of the register are read back and compared with a shadow model. That read-back also confirms that slots beyond the count are untouched.

// File: rtl/svl_pkg.sv
package svl_pkg;
    localparam int SVL_AW        = 24;
    localparam int SVL_DW        = 64;
    localparam int SVL_CW        = 8;
    localparam int SVL_NVR       = 8;
    localparam int SVL_NEL       = 64;
    localparam int SVL_NBANK     = 16;
    localparam int SVL_BANK_BUSY = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } svl_state_e;
endpackage

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            step_q <= '0;
        end else if (load) begin
            addr   <= base;
            step_q <= step;
        end else if (advance) begin
            addr <= addr + step_q;
        end
    end
endmodule

// File: rtl/svl_bank_timer.sv
module svl_bank_timer #(
    parameter int NBANK = 16,
    parameter int BUSY  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic [$clog2(NBANK)-1:0] issue_bank,
    output logic [NBANK-1:0]         bank_free
);
    localparam int BW   = $clog2(NBANK);
    localparam int CNTW = $clog2(BUSY + 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CNTW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (issue && issue_bank == BW'(g)) begin
                cnt <= CNTW'(BUSY - 1);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end

        assign bank_free[g] = (cnt == '0);
    end

    // R4: a request only reaches a bank that has finished its previous access
    p_bank_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> bank_free[issue_bank]);

    if (BUSY > 1) begin : g_hold
        // R4: the bank just used is reported occupied on the following cycle
        p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            issue |=> !bank_free[$past(issue_bank)]);
    end
endmodule

// File: rtl/svl_vreg_file.sv
module svl_vreg_file #(
    parameter int NVR = 8,
    parameter int NEL = 64,
    parameter int DW  = 64
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [$clog2(NVR)-1:0] wsel,
    input  logic [$clog2(NEL)-1:0] widx,
    input  logic [DW-1:0]          wdata,
    input  logic [$clog2(NVR)-1:0] rsel_a,
    input  logic [$clog2(NEL)-1:0] ridx_a,
    output logic [DW-1:0]          rdata_a,
    input  logic [$clog2(NVR)-1:0] rsel_b,
    input  logic [$clog2(NEL)-1:0] ridx_b,
    output logic [DW-1:0]          rdata_b
);
    localparam int DEPTH = NVR * NEL;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[{wsel, widx}] <= wdata;
        end
    end

    assign rdata_a = store_q[{rsel_a, ridx_a}];
    assign rdata_b = store_q[{rsel_b, ridx_b}];
endmodule

// File: rtl/svl_loader.sv
module svl_loader
    import svl_pkg::*;
#(
    parameter int AW        = SVL_AW,
    parameter int DW        = SVL_DW,
    parameter int CW        = SVL_CW,
    parameter int NVR       = SVL_NVR,
    parameter int NEL       = SVL_NEL,
    parameter int NBANK     = SVL_NBANK,
    parameter int BANK_BUSY = SVL_BANK_BUSY
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     store_dir,
    input  logic [$clog2(NVR)-1:0]   vr_sel,
    input  logic [AW-1:0]            base_addr,
    input  logic [AW-1:0]            stride,
    input  logic [$clog2(NEL+1)-1:0] vec_len,
    output logic                     busy,
    output logic                     done,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic                     mem_rvalid,
    input  logic [DW+CW-1:0]         mem_rdata,
    input  logic [$clog2(NVR)-1:0]   vr_rd_sel,
    input  logic [$clog2(NEL)-1:0]   vr_rd_idx,
    output logic [DW-1:0]            vr_rd_data
);
    localparam int SW = $clog2(NVR);
    localparam int IW = $clog2(NEL);
    localparam int LW = $clog2(NEL + 1);
    localparam int BW = $clog2(NBANK);

    svl_state_e    state, nxt;
    logic          xfer_store;
    logic [SW-1:0] xfer_sel;
    logic [IW-1:0] len_m1;
    logic [IW-1:0] len_clamp;
    logic [IW-1:0] iss_idx;
    logic [IW-1:0] wr_idx;
    logic [AW-1:0] cur_addr;
    logic [NBANK-1:0] bank_free;
    logic          bank_ok;
    logic          accept;
    logic          last_issue;
    logic          last_write;
    logic          vr_we;

    // element count clamp: 0 -> 1 element, above NEL -> NEL elements
    always_comb begin
        if (vec_len == '0) begin
            len_clamp = '0;
        end else if (vec_len > LW'(NEL)) begin
            len_clamp = IW'(NEL - 1);
        end else begin
            len_clamp = IW'(vec_len - 1'b1);
        end
    end

    assign accept     = (state == ST_IDLE) && start;
    assign bank_ok    = bank_free[cur_addr[BW-1:0]];
    assign last_issue = mem_req && (iss_idx == len_m1);
    assign last_write = mem_rvalid && (wr_idx == len_m1);
    assign vr_we      = mem_rvalid && !xfer_store &&
                        (state == ST_ISSUE || state == ST_DRAIN);
    assign mem_addr   = cur_addr;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_ISSUE;
            ST_ISSUE:  if (last_issue) nxt = xfer_store ? ST_FINISH : ST_DRAIN;
            ST_DRAIN:  if (last_write) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                busy    = 1'b1;
                mem_req = bank_ok;
                mem_we  = xfer_store;
            end
            ST_DRAIN:  busy = 1'b1;
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
        endcase
    end

    // transfer parameters and element counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_store <= 1'b0;
            xfer_sel   <= '0;
            len_m1     <= '0;
            iss_idx    <= '0;
            wr_idx     <= '0;
        end else if (accept) begin
            xfer_store <= store_dir;
            xfer_sel   <= vr_sel;
            len_m1     <= len_clamp;
            iss_idx    <= '0;
            wr_idx     <= '0;
        end else begin
            if (mem_req) iss_idx <= iss_idx + 1'b1;
            if (vr_we)   wr_idx  <= wr_idx + 1'b1;
        end
    end

    svl_addr_gen #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (mem_req),
        .base    (base_addr),
        .step    (stride),
        .addr    (cur_addr)
    );

    svl_bank_timer #(.NBANK(NBANK), .BUSY(BANK_BUSY)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (mem_req),
        .issue_bank (cur_addr[BW-1:0]),
        .bank_free  (bank_free)
    );

    svl_vreg_file #(.NVR(NVR), .NEL(NEL), .DW(DW)) u_vregs (
        .clk     (clk),
        .we      (vr_we),
        .wsel    (xfer_sel),
        .widx    (wr_idx),
        .wdata   (mem_rdata[DW-1:0]),
        .rsel_a  (xfer_sel),
        .ridx_a  (iss_idx),
        .rdata_a (mem_wdata),
        .rsel_b  (vr_rd_sel),
        .ridx_b  (vr_rd_idx),
        .rdata_b (vr_rd_data)
    );

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: no memory traffic outside an active transfer
    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: never more requests than the clamped element count
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (iss_idx <= len_m1));

    // R2: a start seen mid-transfer leaves the captured parameters alone
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(xfer_sel) && $stable(len_m1) && $stable(xfer_store)));

    // R6: the drain phase sends nothing, and load responses carry defined words
    p_drain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !mem_req);
    p_resp_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> !$isunknown(mem_rdata));
endmodule

// File: tb/svl_loader_bench.sv
`timescale 1ns/1ps
module svl_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        store_dir = 1'b0;
    logic [2:0]  vr_sel = '0;
    logic [23:0] base_addr = '0;
    logic [23:0] stride = '0;
    logic [6:0]  vec_len = '0;
    logic        busy, done, mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [71:0] mem_rdata = '0;
    logic [2:0]  vr_rd_sel = '0;
    logic [5:0]  vr_rd_idx = '0;
    logic [63:0] vr_rd_data;

    int n_total = 0;
    int n_bad = 0;
    bit finished = 0;
    int cyc = 0;

    logic [63:0] shadow [8][64];
    int          rec_cyc [64];
    logic [23:0] rec_addr [64];
    logic        rec_we [64];
    logic [63:0] rec_wd [64];
    int          rec_n = 0;
    int          done_cyc = -1;

    always #5 clk = ~clk;

    svl_loader u_svl_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .store_dir(store_dir),
        .vr_sel(vr_sel), .base_addr(base_addr), .stride(stride), .vec_len(vec_len),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .vr_rd_sel(vr_rd_sel), .vr_rd_idx(vr_rd_idx),
        .vr_rd_data(vr_rd_data)
    );

    function automatic logic [63:0] word_of(input logic [23:0] a);
        return {a, ~a, a[15:0]};
    endfunction

    function automatic logic [7:0] chk_of(input logic [23:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // memory model: read data returns one cycle after the request
    always @(posedge clk) begin
        cyc        <= cyc + 1;
        mem_rvalid <= mem_req && !mem_we;
        mem_rdata  <= {chk_of(mem_addr), word_of(mem_addr)};
    end

    // request and completion monitor
    always @(negedge clk) begin
        if (mem_req) begin
            if (rec_n < 64) begin
                rec_cyc[rec_n]  = cyc;
                rec_addr[rec_n] = mem_addr;
                rec_we[rec_n]   = mem_we;
                rec_wd[rec_n]   = mem_wdata;
            end
            rec_n++;
        end
        if (done && done_cyc < 0) done_cyc = cyc;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input bit st, input int sel, input logic [23:0] base,
                            input logic [23:0] str, input int vlen_in, input bit poke);
        int n;
        int freeb [16];
        int et [64];
        logic [23:0] ea [64];
        logic [23:0] a;
        int t;
        int s0;
        bit seen;
        n = (vlen_in == 0) ? 1 : ((vlen_in > 64) ? 64 : vlen_in);
        a = base;
        t = 0;
        for (int b = 0; b < 16; b++) freeb[b] = 0;
        for (int k = 0; k < n; k++) begin
            ea[k] = a;
            if (t < freeb[a[3:0]]) t = freeb[a[3:0]];
            et[k] = t;
            freeb[a[3:0]] = t + 4;
            t++;
            a = a + str;
        end
        @(negedge clk);
        rec_n = 0;
        done_cyc = -1;
        start = 1'b1;
        store_dir = st;
        vr_sel = 3'(sel);
        base_addr = base;
        stride = str;
        vec_len = 7'(vlen_in);
        @(negedge clk);
        start = 1'b0;
        s0 = cyc;
        seen = 0;
        for (int w = 0; w < 2000; w++) begin
            if (done_cyc >= 0) begin
                seen = 1;
                break;
            end
            @(negedge clk);
            if (poke && w == 3) begin
                start = 1'b1;
                store_dir = ~st;
                vr_sel = 3'(sel + 1);
                base_addr = ~base;
                vec_len = 7'd2;
            end
            if (poke && w == 4) start = 1'b0;
        end
        if (!seen) check(0, "R8", "watchdog: no done", 64'(0), 64'(1));
        repeat (6) @(negedge clk);
        check(rec_n == n, poke ? "R2" : "R5", "request count", 64'(rec_n), 64'(n));
        for (int k = 0; k < n && k < rec_n; k++) begin
            check(rec_addr[k] == ea[k], poke ? "R2" : "R3", "element address",
                  64'(rec_addr[k]), 64'(ea[k]));
            check(rec_cyc[k] == s0 + et[k], "R4", "request cycle",
                  64'(rec_cyc[k]), 64'(s0 + et[k]));
            check(rec_we[k] == st, st ? "R7" : "R6", "write strobe",
                  64'(rec_we[k]), 64'(st));
            if (st) check(rec_wd[k] == shadow[sel][k], "R7", "store data",
                          rec_wd[k], shadow[sel][k]);
        end
        check(done_cyc == s0 + et[n-1] + (st ? 1 : 2), "R8", "done cycle",
              64'(done_cyc), 64'(s0 + et[n-1] + (st ? 1 : 2)));
        if (!st) begin
            for (int k = 0; k < n; k++) shadow[sel][k] = word_of(ea[k]);
        end
        for (int k = 0; k < 64; k++) begin
            vr_rd_sel = 3'(sel);
            vr_rd_idx = 6'(k);
            #1;
            check(vr_rd_data === shadow[sel][k], (k < n) ? "R6" : "R5",
                  "register element", vr_rd_data, shadow[sel][k]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_bad++;
            n_total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "in reset",
              64'({busy, done, mem_req}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R1", "after reset",
              64'({busy, done, mem_req}), 64'(0));

        // fill every register with unit-stride full loads
        for (int s = 0; s < 8; s++) run_xfer(0, s, 24'(s * 64 + 16), 24'd1, 64, 0);
        // read port on a known element
        vr_rd_sel = 3'd5; vr_rd_idx = 6'd7; #1;
        check(vr_rd_data == word_of(24'(5 * 64 + 16 + 7)), "R9", "read port",
              vr_rd_data, word_of(24'(5 * 64 + 16 + 7)));
        // same-bank strides, zero stride, negative stride with wrap
        run_xfer(0, 1, 24'h000100, 24'd16, 10, 0);
        run_xfer(0, 2, 24'h000203, 24'd8, 12, 0);
        run_xfer(0, 3, 24'h00ABCD, 24'd0, 5, 0);
        run_xfer(0, 4, 24'h000005, 24'hFFFFFF, 20, 0);
        // length clamps
        run_xfer(0, 6, 24'h001000, 24'd2, 0, 0);
        run_xfer(0, 7, 24'h002000, 24'd4, 100, 0);
        // stores
        run_xfer(1, 2, 24'h030000, 24'd3, 64, 0);
        run_xfer(1, 7, 24'h040000, 24'd16, 7, 0);
        // start pulse during a running transfer
        run_xfer(0, 0, 24'h050000, 24'd1, 64, 1);
        run_xfer(1, 0, 24'h060000, 24'd8, 40, 1);

        for (int i = 0; i < 30; i++) begin
            logic [23:0] str;
            case ($urandom % 8)
                0: str = 24'd1;
                1: str = 24'd2;
                2: str = 24'd4;
                3: str = 24'd8;
                4: str = 24'd16;
                5: str = 24'd0;
                6: str = 24'hFFFFFD;
                default: str = 24'($urandom);
            endcase
            run_xfer(1'($urandom % 2), int'($urandom % 8), 24'($urandom), str,
                     int'($urandom % 71), 0);
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule